// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of peripheral sources (32 by default) and presents one combined request line to the host processor. Each source can be enabled or masked individually. A global enable in the configuration register gates the host line. The block selects one winning source among those that are pending, unmasked and not already in service. It reports that source's number through a vector register.

The host talks to the block over a simple synchronous register port with four word addresses: configuration, mask, in-service and vector. To service an interrupt, the host writes the acknowledge bit to the vector register and then reads the latched number back. The acknowledge also marks the winning source as in service. When servicing ends, the host writes a one to that source's in-service bit.

Source slot 0 is reserved for the error vector. If the host acknowledges while nothing is eligible, the vector register reports 0 and no source is marked. This happens, for example, when a request was masked between raising the line and the acknowledge. The host only needs to acknowledge such an event. A latched vector stays frozen while its in-service bit is set. Only a higher-ranked source can replace it (nesting).

Top module: `vpic_top`

## Requirements
- R1: After reset, all four registers read as zero and `host_irq` is low.
- R2: Mask register (address 1) holds one bit per source: 1 enables the source, 0 masks it. A masked source is never chosen by an acknowledge.
- R3: Writing the in-service register (address 2) clears every bit written as 1. Bits written as 0 keep their value, and a write never sets a bit.
- R4: Writing address 3 with bit 0 set is an acknowledge. The latched vector then reads back from address 3 in the top VEC_W bits of the low 16-bit half: bits 15:11 for 32 sources, bits 15:13 for 8. All other bits read as zero.
- R5: Configuration bit 0 is the global enable. While it is 0, `host_irq` stays low.
- R6: `host_irq` is high one cycle after at least one source is pending, unmasked, not in service and not slot 0, provided the global enable is set.
- R7: Among eligible sources, an acknowledge selects the highest source number.
- R8: The configuration field at bits 8 upward (VEC_W bits wide) names a top-priority source. When that source is eligible, it wins over every other source. An acknowledge that selects a source sets that source's in-service bit.
- R9: Source slot 0 never becomes pending. An acknowledge with no eligible source, and no frozen vector, latches vector 0 (the error vector) and sets no in-service bit.
- R10: While the latched vector's in-service bit is set, the vector is frozen. A lower-ranked winner leaves both the vector and the in-service register unchanged. A higher-ranked winner replaces the vector and also becomes in service. The named top-priority source ranks highest; otherwise a larger number ranks higher. Without an acknowledge, the vector never changes.
- R11: Requests are level-sensitive. When a source input drops, that source no longer raises `host_irq`.
- R12: The configuration field at bits 16 upward (LVL_W bits wide) is stored, read back, and driven on `host_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the register selected on the previous cycle |
| src_req | input | NSRC | Level-sensitive source requests |
| host_irq | output | 1 | Combined request to the host |
| host_level | output | LVL_W | Stored request-level field |

## Verification
The bench builds the block with NSRC = 8, which makes VEC_W = 3 and puts the vector in bits 15:13. At this size, every one of the 256 request patterns can be acknowledged under each of the 8 top-priority settings. A further sweep covers all 256 mask values with every source requesting. Directed sequences then cover the nesting and freeze rules, the race case that yields the error vector, level-sensitive release, and the enable gating.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_MASK = 2'd1,
    REG_INSV = 2'd2,
    REG_VEC  = 2'd3
  } vpic_reg_e;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_TOP_LSB = 8;
  localparam int CFG_LVL_LSB = 16;
  localparam int VEC_FIELD_MSB = 15;
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int VEC_W = 5,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [NSRC-1:0]  ack_set,
  output logic             en_q,
  output logic [VEC_W-1:0] top_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [NSRC-1:0]  mask_q,
  output logic [NSRC-1:0]  insv_q
);
  logic wr_cfg, wr_mask, wr_insv;
  logic [NSRC-1:0] insv_d;

  assign wr_cfg  = we && (addr == REG_CFG);
  assign wr_mask = we && (addr == REG_MASK);
  assign wr_insv = we && (addr == REG_INSV);

  always_comb begin
    insv_d = insv_q;
    if (wr_insv) insv_d = insv_d & ~wdata[NSRC-1:0];
    insv_d = insv_d | ack_set;
    insv_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      top_q  <= '0;
      lvl_q  <= '0;
      mask_q <= '0;
      insv_q <= '0;
    end else begin
      if (wr_cfg) begin
        en_q  <= wdata[CFG_EN_BIT];
        top_q <= wdata[CFG_TOP_LSB +: VEC_W];
        lvl_q <= wdata[CFG_LVL_LSB +: LVL_W];
      end
      if (wr_mask) mask_q <= wdata[NSRC-1:0];
      insv_q <= insv_d;
    end
  end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int NSRC  = 32,
  parameter int VEC_W = 5
) (
  input  logic [NSRC-1:0]  elig,
  input  logic [VEC_W-1:0] top,
  output logic             win_vld,
  output logic [VEC_W-1:0] win_idx
);
  logic [VEC_W-1:0] high_idx;

  always_comb begin
    high_idx = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (elig[i]) high_idx = VEC_W'(i);
    end
  end

  always_comb begin
    win_vld = |elig;
    win_idx = elig[top] ? top : high_idx;
  end
endmodule

// File: rtl/vpic_vector.sv
module vpic_vector #(
  parameter int NSRC  = 32,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic             win_vld,
  input  logic [VEC_W-1:0] win_idx,
  input  logic [VEC_W-1:0] top,
  input  logic [NSRC-1:0]  insv_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [NSRC-1:0]  ack_set
);
  localparam logic [VEC_W-1:0] ERR_VEC = '0;

  logic           frozen;
  logic [VEC_W:0] rank_win, rank_cur;
  logic           take;

  always_comb begin
    frozen   = insv_q[vec_q];
    rank_win = (win_idx == top) ? {1'b1, {VEC_W{1'b0}}} : {1'b0, win_idx};
    rank_cur = (vec_q == top) ? {1'b1, {VEC_W{1'b0}}} : {1'b0, vec_q};
    take     = ack && win_vld && (!frozen || (rank_win > rank_cur));
    ack_set  = '0;
    if (take) ack_set[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= ERR_VEC;
    end else if (take) begin
      vec_q <= win_idx;
    end else if (ack && !win_vld && !frozen) begin
      vec_q <= ERR_VEC;
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NSRC-1:0]   src_req,
  output logic              host_irq,
  output logic [LVL_W-1:0]  host_level
);
  localparam int VEC_W = $clog2(NSRC);

  logic             cfg_en;
  logic [VEC_W-1:0] cfg_top;
  logic [LVL_W-1:0] cfg_lvl;
  logic [NSRC-1:0]  mask_q, insv_q, ack_set, elig;
  logic             win_vld, ack_wr;
  logic [VEC_W-1:0] win_idx, vec_q;
  logic [31:0]      rd_mux;
  logic [15:0]      vec_word;

  assign ack_wr = reg_we && (reg_addr == REG_VEC) && reg_wdata[0];

  vpic_regs #(.NSRC(NSRC), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ack_set(ack_set), .en_q(cfg_en), .top_q(cfg_top), .lvl_q(cfg_lvl),
    .mask_q(mask_q), .insv_q(insv_q)
  );

  always_comb begin
    elig    = src_req & mask_q & ~insv_q;
    elig[0] = 1'b0;
  end

  vpic_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .elig(elig), .top(cfg_top), .win_vld(win_vld), .win_idx(win_idx)
  );

  vpic_vector #(.NSRC(NSRC), .VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst(rst), .ack(ack_wr), .win_vld(win_vld), .win_idx(win_idx),
    .top(cfg_top), .insv_q(insv_q), .vec_q(vec_q), .ack_set(ack_set)
  );

  always_comb begin
    vec_word = '0;
    vec_word[VEC_FIELD_MSB -: VEC_W] = vec_q;
    rd_mux = '0;
    case (reg_addr)
      REG_CFG: begin
        rd_mux[CFG_EN_BIT] = cfg_en;
        rd_mux[CFG_TOP_LSB +: VEC_W] = cfg_top;
        rd_mux[CFG_LVL_LSB +: LVL_W] = cfg_lvl;
      end
      REG_MASK: rd_mux[NSRC-1:0] = mask_q;
      REG_INSV: rd_mux[NSRC-1:0] = insv_q;
      default:  rd_mux[15:0] = vec_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      host_irq  <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      host_irq  <= cfg_en && (|elig);
    end
  end

  assign host_level = cfg_lvl;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
  import vpic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [NSRC-1:0]  wr_bits,
  input logic             host_irq,
  input logic             cfg_en,
  input logic [NSRC-1:0]  elig,
  input logic [NSRC-1:0]  insv_q,
  input logic [VEC_W-1:0] vec_q,
  input logic             ack_wr
);
  AST_INSV_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == REG_INSV) |=> ((insv_q & ~$past(insv_q)) == '0)); // R3
  AST_INSV_ONES_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == REG_INSV) |=> ((insv_q & $past(wr_bits)) == '0)); // R3
  AST_EN_GATES_IRQ: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !host_irq); // R5
  AST_IRQ_ON_ELIG: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && elig != '0) |=> host_irq); // R6
  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (rst)
    ack_wr |=> ((vec_q == '0) || insv_q[vec_q])); // R8
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ack_wr |=> $stable(vec_q)); // R10
endmodule

bind vpic_top vpic_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .wr_bits(reg_wdata[NSRC-1:0]), .host_irq(host_irq), .cfg_en(cfg_en),
  .elig(elig), .insv_q(insv_q), .vec_q(vec_q), .ack_wr(ack_wr)
);

// File: tb/vpic_top_test.sv
module vpic_top_test;
  localparam int N = 8;
  localparam int VW = 3;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  src_req = '0;
  logic          host_irq;
  logic [LW-1:0] host_level;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vpic_top #(.NSRC(N), .LVL_W(LW)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
    .host_irq(host_irq), .host_level(host_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic int exp_vec(int p, int m, int t);
    int e = p & m & 32'hFE;
    if (t != 0 && e[t]) return t;
    for (int i = N - 1; i >= 1; i--) if (e[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] vword(int v);
    return 32'(v) << (16 - VW);
  endfunction

  function automatic logic [31:0] cfgw(int en, int t, int l);
    return 32'(en) | (32'(t) << 8) | (32'(l) << 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int ev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset reg", d, 32'h0);
    end
    chk("R1 reset irq", {31'b0, host_irq}, 32'h0);

    // R12 config readback and level output
    wr(2'd0, cfgw(1, 3, 5));
    rd(2'd0, d);
    chk("R12 cfg readback", d, cfgw(1, 3, 5));
    chk("R12 host_level", 32'(host_level), 32'd5);

    // R7 R8 R9 R4 R6: sweep all patterns under every top setting
    wr(2'd1, 32'hFF);
    for (int t = 0; t < N; t++) begin
      for (int p = 0; p < 256; p++) begin
        src_req = N'(p);
        wr(2'd0, cfgw(1, t, 0));
        settle();
        chk("R6 irq sweep", {31'b0, host_irq}, {31'b0, ((p & 32'hFE) != 0)});
        wr(2'd3, 32'h1);
        rd(2'd3, d);
        ev = exp_vec(p, 32'hFF, t);
        chk(t != 0 ? "R8 top vector" : "R7 highest vector", d, vword(ev));
        if (ev != 0) wr(2'd2, 32'h1 << ev);
      end
    end

    // R2 mask sweep with all sources requesting
    src_req = '1;
    wr(2'd0, cfgw(1, 0, 0));
    for (int m = 0; m < 256; m++) begin
      wr(2'd1, 32'(m));
      wr(2'd3, 32'h1);
      rd(2'd3, d);
      ev = exp_vec(32'hFF, m, 0);
      chk("R2 mask vector", d, vword(ev));
      if (ev != 0) wr(2'd2, 32'h1 << ev);
    end

    // R10 freeze and nesting, R3 in-service clears
    wr(2'd1, 32'hFF);
    src_req = N'(8'h08);
    wr(2'd3, 32'h1);
    rd(2'd3, d);  chk("R10 first ack", d, vword(3));
    src_req = N'(8'h0C);
    wr(2'd3, 32'h1);
    rd(2'd3, d);  chk("R10 lower keeps vector", d, vword(3));
    rd(2'd2, d);  chk("R10 lower not in service", d, 32'h08);
    src_req = N'(8'h4C);
    wr(2'd3, 32'h1);
    rd(2'd3, d);  chk("R10 higher nests", d, vword(6));
    rd(2'd2, d);  chk("R10 nested in service", d, 32'h48);
    wr(2'd2, 32'h0);
    rd(2'd2, d);  chk("R3 zeros no effect", d, 32'h48);
    wr(2'd2, 32'h40);
    rd(2'd2, d);  chk("R3 one clears bit", d, 32'h08);
    rd(2'd3, d);  chk("R10 no ack no change", d, vword(6));
    wr(2'd2, 32'hFF);
    rd(2'd2, d);  chk("R3 clear all", d, 32'h0);

    // R9 race: request masked before acknowledge
    src_req = N'(8'h20);
    wr(2'd1, 32'hFF);
    settle();
    chk("R9 irq before mask", {31'b0, host_irq}, 32'h1);
    wr(2'd1, 32'hDF);
    wr(2'd3, 32'h1);
    rd(2'd3, d);  chk("R9 error vector", d, vword(0));
    rd(2'd2, d);  chk("R9 no in-service", d, 32'h0);
    src_req = N'(8'h01);
    wr(2'd1, 32'hFF);
    settle();
    chk("R9 slot0 never pends", {31'b0, host_irq}, 32'h0);

    // R11 level-sensitive release
    src_req = N'(8'h20);
    settle();
    chk("R11 irq high", {31'b0, host_irq}, 32'h1);
    src_req = '0;
    settle();
    chk("R11 irq drops", {31'b0, host_irq}, 32'h0);

    // R5 global enable
    src_req = N'(8'h10);
    wr(2'd0, cfgw(0, 0, 0));
    settle();
    chk("R5 disabled irq", {31'b0, host_irq}, 32'h0);
    wr(2'd0, cfgw(1, 0, 0));
    settle();
    chk("R5 enabled irq", {31'b0, host_irq}, 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule